// File: doc/BRIEF.md
# Dual-Bank GPIO Interrupt Unit

This block watches sixteen general-purpose input pins, organised as two banks of eight. Each pin can raise an interrupt on a low level, a high level, a falling edge or a rising edge. Two configuration bits choose the mode for each pin: a sense bit picks level or edge, and a polarity bit picks low/falling or high/rising. Each pin also has its own enable bit. Edge events are held in a flag until software clears them by writing ones to the bank's clear register. Each bank has a status register that shows the pins with an enabled, active interrupt. A single request line is raised while any status bit in either bank is set.

Software reaches the unit over a plain synchronous register bus. Reads are combinational on the address. Writes take effect on the rising clock edge while the write strobe is high. Each bank has five registers at fixed byte offsets, and both banks use the same relative layout. Pin direction and pin data are handled by other logic.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every sense, polarity and enable bit is 0, every status bit is 0 and `irq_o` is low.
- R2: Pin n (`pin_i[n]`) belongs to bank n/8 at bit n mod 8. Bank 0 registers are sense 0x90, polarity 0x94, clear 0x98, enable 0x9C, status 0xA0. Bank 1 registers are sense 0xAC, polarity 0xB0, clear 0xB4, enable 0xB8, status 0xBC.
- R3: With sense 0, an enabled pin's status bit follows the pin level: it is 1 when the pin equals the polarity bit (1 = high, 0 = low). A pin change reaches the status bit two clock edges after it is applied.
- R4: With sense 1, the selected edge sets a held flag. Polarity 1 selects a rising edge and polarity 0 a falling edge. The flag reaches status three clock edges after the pin change and stays set after the pin returns.
- R5: Writing a mask to a bank's clear register clears the held flag of each pin whose mask bit is 1. Pins whose mask bit is 0 keep their flag. Writing the clear register has no effect on pins in level mode.
- R6: A pin whose enable bit is 0 shows 0 in status and never sets a flag. A flag held before the pin was disabled reappears when the pin is enabled again.
- R7: Sense, polarity and enable registers read back the last value written. Clear registers read as 0. Writes to status registers are ignored. Any other address reads as 0.
- R8: `irq_o` is high exactly when at least one status bit of either bank is 1.
- R9: If an edge event and a clear of the same pin fall on the same clock edge, the flag stays set.
- R10: Leaving edge mode (sense written 0) discards the pin's held flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_i | input | 16 | Asynchronous interrupt source pins |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted configuration bit shows at once as a wrong read-back value. Within three edges it also shows as a status bit that ignores its pin, or one that fires on the wrong level or edge. A held flag that fails to set, clear or stay masked shows in the next status read and in `irq_o` in the same cycle. Fixed checks cover the latency, clear and simultaneous set/clear cases. A long run of random pins and register writes is compared every cycle against a bench model, so a fault shows within a few cycles of the first stimulus that exposes it.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int ADDR_W = 8,
  parameter int PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [PORT_W-1:0]     bus_wdata,
  output logic [PORT_W-1:0]     bus_rdata,
  input  logic [2*PORT_W-1:0]   pin_i,
  output logic                  irq_o
);
  localparam int LINES = 2 * PORT_W;

  logic [LINES-1:0] sync1, sync2, prev;
  logic [LINES-1:0] sense_v, pol_v, en_v, clr_v;
  logic [LINES-1:0] hit, lvl_match, flag_q, stat;
  logic [1:0][PORT_W-1:0] rd_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = (p == 0) ? ADDR_W'(8'h90) : ADDR_W'(8'hAC);
    localparam logic [ADDR_W-1:0] A_SENSE = BASE;
    localparam logic [ADDR_W-1:0] A_POL   = BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CLR   = BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_EN    = BASE + ADDR_W'(12);
    localparam logic [ADDR_W-1:0] A_STAT  = BASE + ADDR_W'(16);

    logic [PORT_W-1:0] sense_r, pol_r, en_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sense_r <= '0;
        pol_r   <= '0;
        en_r    <= '0;
      end else if (bus_we) begin
        if (bus_addr == A_SENSE) sense_r <= bus_wdata;
        if (bus_addr == A_POL)   pol_r   <= bus_wdata;
        if (bus_addr == A_EN)    en_r    <= bus_wdata;
      end
    end

    assign sense_v[p*PORT_W +: PORT_W] = sense_r;
    assign pol_v[p*PORT_W +: PORT_W]   = pol_r;
    assign en_v[p*PORT_W +: PORT_W]    = en_r;
    assign clr_v[p*PORT_W +: PORT_W]   = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;

    assign rd_part[p] = (bus_addr == A_SENSE) ? sense_r :
                        (bus_addr == A_POL)   ? pol_r   :
                        (bus_addr == A_EN)    ? en_r    :
                        (bus_addr == A_STAT)  ? stat[p*PORT_W +: PORT_W] : '0;
  end

  assign bus_rdata = rd_part[0] | rd_part[1];

  assign hit       = en_v & sense_v & ((pol_v & sync2 & ~prev) | (~pol_v & ~sync2 & prev));
  assign lvl_match = (pol_v & sync2) | (~pol_v & ~sync2);
  assign stat      = en_v & ((sense_v & flag_q) | (~sense_v & lvl_match));
  assign irq_o     = |stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= sense_v & (hit | (flag_q & ~clr_v));
  end

  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~flag_q) == '0));

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(clr_v) & ~$past(hit)) == '0));

  assert_disabled_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(en_v)) == '0));

  assert_level_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(sense_v)) == '0));

  assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8'h98) || bus_addr == ADDR_W'(8'hB4)) |-> bus_rdata == '0);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v == '0) |-> !irq_o);
endmodule

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  logic clk = 0, rst_n = 0, bus_we = 0, irq_o;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [15:0] pin_i = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .irq_o(irq_o));

  // bench model
  logic [15:0] m_s1 = 0, m_s2 = 0, m_prev = 0, m_flag = 0, m_sense = 0, m_pol = 0, m_en = 0;

  function automatic logic [15:0] m_stat();
    logic [15:0] lvl = (m_pol & m_s2) | (~m_pol & ~m_s2);
    return m_en & ((m_sense & m_flag) | (~m_sense & lvl));
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    logic [15:0] s = m_stat();
    case (a)
      8'h90: return m_sense[7:0];  8'hAC: return m_sense[15:8];
      8'h94: return m_pol[7:0];    8'hB0: return m_pol[15:8];
      8'h9C: return m_en[7:0];     8'hB8: return m_en[15:8];
      8'hA0: return s[7:0];        8'hBC: return s[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0; m_sense <= 0; m_pol <= 0; m_en <= 0;
    end else begin
      logic [15:0] hit, clr;
      hit = m_en & m_sense & ((m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev));
      clr = 0;
      if (bus_we) begin
        case (bus_addr)
          8'h90: m_sense[7:0] <= bus_wdata;  8'hAC: m_sense[15:8] <= bus_wdata;
          8'h94: m_pol[7:0]   <= bus_wdata;  8'hB0: m_pol[15:8]   <= bus_wdata;
          8'h9C: m_en[7:0]    <= bus_wdata;  8'hB8: m_en[15:8]    <= bus_wdata;
          8'h98: clr[7:0] = bus_wdata;       8'hB4: clr[15:8] = bus_wdata;
          default: ;
        endcase
      end
      m_flag <= m_sense & (hit | (m_flag & ~clr));
      m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    step();
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic finish_up();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] addrs [12] = '{8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hAC,
                               8'hB0, 8'hB4, 8'hB8, 8'hBC, 8'h00, 8'hA4};
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    foreach (addrs[i]) rd(addrs[i], 8'h00, "R1");
    chk({7'd0, irq_o}, 8'h00, "R1 irq");

    // R7 readback
    wr(8'h94, 8'h5A); rd(8'h94, 8'h5A, "R7 pol");
    wr(8'hB8, 8'hC3); rd(8'hB8, 8'hC3, "R7 en");
    wr(8'hB8, 8'h00); wr(8'h94, 8'h00);
    rd(8'h98, 8'h00, "R7 clr"); rd(8'hA4, 8'h00, "R7 unmapped");
    wr(8'hA0, 8'hFF); rd(8'hA0, 8'h00, "R7 status write ignored");

    // R3 level high on pin 2
    wr(8'h94, 8'h04); wr(8'h9C, 8'h04);
    pin_i[2] = 1;
    step(); rd(8'hA0, 8'h00, "R3 latency");
    step(); rd(8'hA0, 8'h04, "R3 level high");
    chk({7'd0, irq_o}, 8'h01, "R8 irq");
    wr(8'h98, 8'h04); rd(8'hA0, 8'h04, "R5 clear ignored in level mode");

    // R4 rising edge on pin 11 -> bank 1 bit 3 (R2)
    wr(8'hAC, 8'h08); wr(8'hB0, 8'h08); wr(8'hB8, 8'h08);
    pin_i[11] = 1;
    step(2); rd(8'hBC, 8'h00, "R4 latency");
    step(); rd(8'hBC, 8'h08, "R4 rising edge");
    rd(8'hA0, 8'h04, "R2 bank separation");
    pin_i[11] = 0; step(4);
    rd(8'hBC, 8'h08, "R4 flag held");

    // R5 clear
    wr(8'hB4, 8'hF7); rd(8'hBC, 8'h08, "R5 zero mask keeps");
    wr(8'hB4, 8'h08); rd(8'hBC, 8'h00, "R5 clear");

    // R6 disable masks, re-enable reveals
    pin_i[11] = 1; step(3);
    rd(8'hBC, 8'h08, "R6 setup");
    wr(8'hB8, 8'h00); rd(8'hBC, 8'h00, "R6 masked");
    pin_i[11] = 0; step(3); pin_i[11] = 1; step(3);
    wr(8'hB8, 8'h08); rd(8'hBC, 8'h08, "R6 flag kept");
    wr(8'hB4, 8'h08);
    wr(8'hB8, 8'h00); pin_i[11] = 0; step(3); pin_i[11] = 1; step(3);
    wr(8'hB8, 8'h08); rd(8'hBC, 8'h00, "R6 no set while disabled");

    // R9 edge and clear same edge
    pin_i[11] = 0; step(3);
    pin_i[11] = 1; step(2);
    wr(8'hB4, 8'h08); rd(8'hBC, 8'h08, "R9 set wins");

    // R10 leaving edge mode drops flag
    wr(8'hAC, 8'h00); wr(8'hAC, 8'h08); rd(8'hBC, 8'h00, "R10 flag discarded");

    // R8 irq off when all clear
    wr(8'h9C, 8'h00);
    chk({7'd0, irq_o}, 8'h00, "R8 irq low");

    // random phase against model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) pin_i[$urandom_range(0, 15)] ^= 1'b1;
      bus_addr = addrs[$urandom_range(0, 11)];
      bus_we = ($urandom_range(0, 3) == 0);
      bus_wdata = 8'($urandom);
      #1;
      chk(bus_rdata, exp_read(bus_addr), "R3/R4 random read");
      chk({7'd0, irq_o}, {7'd0, |m_stat()}, "R8 random irq");
      step();
      bus_we = 0;
    end
    finish_up();
  end
endmodule